// File: doc/BRIEF.md
# Lockable Encryption Region Matcher

This block keeps a table of eight address windows and classifies every bus address presented on its lookup input. For each address it reports whether any window claims it, which window that is, whether accesses there must pass through the encryption engine, and the window's access attributes (debug, sandbox, safebox, execute-only). The encryption datapath and any violation response live elsewhere; this block only supplies the decision.

Windows are set up through a single-cycle write port. A write names a region, a register select, a requesting domain and a data word. Each window has a lower bound, an upper bound and an attribute word. Bounds are 8-byte granular and the window is half-open: the lower bound is included and the upper bound is excluded. A global enable gates the whole table. For hardening, each window has set-only freeze bits for its lower bound, upper bound and attribute word. Each of the two domains also has a per-window control word that can stop that domain's writes to the window and can itself be frozen. Only reset undoes a freeze.

Top module: `enc_region_matcher`

## Requirements
- R1: The lookup outputs (`hit`, `hit_region`, `hit_encrypt`, `hit_attr`) reflect the `lookup_addr` value present at the preceding rising clock edge and the register state before that edge.
- R2: Region r matches address a when the global enable is set, bit 0 (valid) of its attribute word is set, and bottom <= a[31:3] < top, where bottom and top are the stored bounds. An address equal to the bottom matches. An address equal to the top does not match.
- R3: When several regions match, the lowest-numbered one is reported.
- R4: The global enable is written with select 4, using bit 0 of the data, and resets to 0. While it is 0, `hit` stays low for every address.
- R5: On a hit, `hit_encrypt` equals attribute bit 5, and `hit_attr` equals attribute bits [4:1] (bit 4 execute-only, bit 3 safebox, bit 2 sandbox, bit 1 debug). Without a hit, `hit_region`, `hit_encrypt` and `hit_attr` are all zero.
- R6: Register selects are: 0 lower bound, 1 upper bound, 2 attribute word (6 bits), 3 domain control, 4 global enable, 5 freeze. A bound write with nonzero data bits [2:0] is rejected and leaves the bound unchanged. Such a write also raises `cfg_err` in the following cycle. In every other cycle `cfg_err` is low.
- R7: A select 5 write sets freeze bits for the addressed region: data bit 0 freezes the lower bound, bit 1 the upper bound, bit 2 the attribute word. Freeze bits are only ever set, never cleared by writes. A write to a frozen register is ignored.
- R8: A select 3 write updates the control word of the domain given by `cfg_domain`: data bit 0 is write-disable, bit 1 is freeze. Once that word's freeze bit is set, later writes to the word are ignored until reset.
- R9: While domain d has write-disable set for region r, writes tagged with domain d using selects 0, 1, 2 or 5 to region r are ignored. The same writes from the other domain still take effect unless frozen.
- R10: After reset, all bounds, attributes, freeze bits, control words and the global enable are zero, so no address hits and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select (R6 encoding) |
| cfg_region | input | 3 | Region addressed by the write |
| cfg_domain | input | 1 | Domain that issues the write |
| cfg_wdata | input | 32 | Write data |
| cfg_err | output | 1 | Misaligned bound write seen in the previous cycle |
| lookup_addr | input | 32 | Bus address to classify |
| hit | output | 1 | Some enabled region matched |
| hit_region | output | 3 | Index of the winning region |
| hit_encrypt | output | 1 | Encryption required for the access |
| hit_attr | output | 4 | Execute-only, safebox, sandbox, debug of the winner |

## Verification
On every cycle the assertions check four things. Freeze bits and domain freeze bits never fall outside reset. A cleared global enable forces a miss one cycle later. Outputs are zero whenever there is no hit. `cfg_err` follows exactly the misaligned bound writes. Other behaviour can only be shown by the bench's scenarios, because each needs a written configuration followed by a probe: which region wins an overlap, exact behaviour at the upper and lower bounds, that a rejected or frozen write really left the old bound in place, and which domain's writes get through once write-disable is set.

// File: rtl/enc_rm_pkg.sv
package enc_rm_pkg;

  typedef enum logic [2:0] {
    SEL_BOT    = 3'd0,
    SEL_TOP    = 3'd1,
    SEL_ATTR   = 3'd2,
    SEL_DCTL   = 3'd3,
    SEL_GLOBAL = 3'd4,
    SEL_FREEZE = 3'd5
  } cfg_sel_e;

  // attribute word, bit 0 is valid, bit 5 is encrypt
  typedef struct packed {
    logic encrypt;
    logic xonly;
    logic safebox;
    logic sandbox;
    logic debug;
    logic valid;
  } attr_t;

  localparam int unsigned ATTR_W   = 6;
  localparam int unsigned GRAN_LSB = 3;   // 8-byte bound granularity
  localparam int unsigned FRZ_BOT  = 0;
  localparam int unsigned FRZ_TOP  = 1;
  localparam int unsigned FRZ_ATTR = 2;
  localparam int unsigned FRZ_W    = 3;

endpackage

// File: rtl/enc_rm_region.sv
module enc_rm_region
  import enc_rm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned NUM_DOMAINS = 2,
  parameter int unsigned DOM_W       = 1,
  localparam int unsigned BW         = ADDR_W - GRAN_LSB
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  cfg_sel_e               sel,
  input  logic [DOM_W-1:0]       dom,
  input  logic [ADDR_W-1:0]      wdata,
  output logic [BW-1:0]          bot,
  output logic [BW-1:0]          top,
  output attr_t                  attr,
  output logic [FRZ_W-1:0]       frz,
  output logic [NUM_DOMAINS-1:0] dfrz
);

  logic [BW-1:0]          bot_q, bot_d, top_q, top_d;
  attr_t                  attr_q, attr_d;
  logic [FRZ_W-1:0]       frz_q, frz_d;
  logic [NUM_DOMAINS-1:0] dwd_q, dwd_d, dfrz_q, dfrz_d;
  logic                   blocked, aligned;
  logic                   bot_en, top_en, attr_en, frz_en, dctl_en;

  // write qualification
  always_comb begin
    blocked = 1'b0;
    for (int d = 0; d < NUM_DOMAINS; d++) begin
      if (dom == DOM_W'(d) && dwd_q[d]) blocked = 1'b1;
    end
    aligned = (wdata[GRAN_LSB-1:0] == '0);
    bot_en  = wr_en && (sel == SEL_BOT)    && aligned && !frz_q[FRZ_BOT]  && !blocked;
    top_en  = wr_en && (sel == SEL_TOP)    && aligned && !frz_q[FRZ_TOP]  && !blocked;
    attr_en = wr_en && (sel == SEL_ATTR)   && !frz_q[FRZ_ATTR] && !blocked;
    frz_en  = wr_en && (sel == SEL_FREEZE) && !blocked;
    dctl_en = wr_en && (sel == SEL_DCTL);
  end

  // next state
  always_comb begin
    bot_d  = wdata[ADDR_W-1:GRAN_LSB];
    top_d  = wdata[ADDR_W-1:GRAN_LSB];
    attr_d = attr_t'(wdata[ATTR_W-1:0]);
    frz_d  = frz_q | wdata[FRZ_W-1:0];
    dwd_d  = dwd_q;
    dfrz_d = dfrz_q;
    for (int d = 0; d < NUM_DOMAINS; d++) begin
      if (dctl_en && dom == DOM_W'(d) && !dfrz_q[d]) begin
        dwd_d[d]  = wdata[0];
        dfrz_d[d] = wdata[1];
      end
    end
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bot_q  <= '0;
      top_q  <= '0;
      attr_q <= '0;
      frz_q  <= '0;
      dwd_q  <= '0;
      dfrz_q <= '0;
    end else begin
      if (bot_en)  bot_q  <= bot_d;
      if (top_en)  top_q  <= top_d;
      if (attr_en) attr_q <= attr_d;
      if (frz_en)  frz_q  <= frz_d;
      if (dctl_en) begin
        dwd_q  <= dwd_d;
        dfrz_q <= dfrz_d;
      end
    end
  end

  assign bot  = bot_q;
  assign top  = top_q;
  assign attr = attr_q;
  assign frz  = frz_q;
  assign dfrz = dfrz_q;

endmodule

// File: rtl/enc_rm_match.sv
module enc_rm_match
  import enc_rm_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned BW          = 29,
  parameter int unsigned IDX_W       = 3
) (
  input  logic [BW-1:0] addr_g,
  input  logic          global_en,
  input  logic [BW-1:0] bot  [NUM_REGIONS],
  input  logic [BW-1:0] top  [NUM_REGIONS],
  input  attr_t         attr [NUM_REGIONS],
  output logic          hit,
  output logic [IDX_W-1:0] idx,
  output attr_t         win_attr
);

  logic [NUM_REGIONS-1:0] in_rng;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_cmp
    assign in_rng[r] = global_en && attr[r].valid &&
                       (addr_g >= bot[r]) && (addr_g < top[r]);
  end

  // priority: walk downward so the lowest index is the last to win
  always_comb begin
    hit      = 1'b0;
    idx      = '0;
    win_attr = '0;
    for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
      if (in_rng[r]) begin
        hit      = 1'b1;
        idx      = IDX_W'(r);
        win_attr = attr[r];
      end
    end
  end

endmodule

// File: rtl/enc_region_matcher.sv
module enc_region_matcher
  import enc_rm_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned NUM_DOMAINS = 2,
  localparam int unsigned IDX_W      = $clog2(NUM_REGIONS),
  localparam int unsigned DOM_W      = (NUM_DOMAINS > 1) ? $clog2(NUM_DOMAINS) : 1,
  localparam int unsigned BW         = ADDR_W - GRAN_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [IDX_W-1:0]  cfg_region,
  input  logic [DOM_W-1:0]  cfg_domain,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              cfg_err,
  input  logic [ADDR_W-1:0] lookup_addr,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_region,
  output logic              hit_encrypt,
  output logic [3:0]        hit_attr
);

  cfg_sel_e sel_e;
  assign sel_e = cfg_sel_e'(cfg_sel);

  logic [BW-1:0] bot  [NUM_REGIONS];
  logic [BW-1:0] top  [NUM_REGIONS];
  attr_t         attr [NUM_REGIONS];
  logic [NUM_REGIONS*FRZ_W-1:0]       lock_flat;
  logic [NUM_REGIONS*NUM_DOMAINS-1:0] dlock_flat;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_reg
    logic wr_r;
    assign wr_r = cfg_we && (cfg_region == IDX_W'(r));
    enc_rm_region #(
      .ADDR_W      (ADDR_W),
      .NUM_DOMAINS (NUM_DOMAINS),
      .DOM_W       (DOM_W)
    ) u_region (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_r),
      .sel   (sel_e),
      .dom   (cfg_domain),
      .wdata (cfg_wdata),
      .bot   (bot[r]),
      .top   (top[r]),
      .attr  (attr[r]),
      .frz   (lock_flat[r*FRZ_W +: FRZ_W]),
      .dfrz  (dlock_flat[r*NUM_DOMAINS +: NUM_DOMAINS])
    );
  end

  // global enable
  logic glob_q, glob_d, glob_en;
  assign glob_en = cfg_we && (sel_e == SEL_GLOBAL);
  assign glob_d  = cfg_wdata[0];

  // misaligned bound detection
  logic err_q, err_d;
  assign err_d = cfg_we && ((sel_e == SEL_BOT) || (sel_e == SEL_TOP)) &&
                 (cfg_wdata[GRAN_LSB-1:0] != '0);

  // combinational match
  logic             m_hit;
  logic [IDX_W-1:0] m_idx;
  attr_t            m_attr;

  enc_rm_match #(
    .NUM_REGIONS (NUM_REGIONS),
    .BW          (BW),
    .IDX_W       (IDX_W)
  ) u_match (
    .addr_g    (lookup_addr[ADDR_W-1:GRAN_LSB]),
    .global_en (glob_q),
    .bot       (bot),
    .top       (top),
    .attr      (attr),
    .hit       (m_hit),
    .idx       (m_idx),
    .win_attr  (m_attr)
  );

  // output next state
  logic             hit_q, hit_d, enc_q, enc_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [3:0]       attr_q, attr_d;

  always_comb begin
    hit_d  = m_hit;
    idx_d  = m_hit ? m_idx : '0;
    enc_d  = m_hit && m_attr.encrypt;
    attr_d = m_hit ? {m_attr.xonly, m_attr.safebox, m_attr.sandbox, m_attr.debug} : 4'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_q <= 1'b0;
      err_q  <= 1'b0;
      hit_q  <= 1'b0;
      idx_q  <= '0;
      enc_q  <= 1'b0;
      attr_q <= '0;
    end else begin
      if (glob_en) glob_q <= glob_d;
      err_q  <= err_d;
      hit_q  <= hit_d;
      idx_q  <= idx_d;
      enc_q  <= enc_d;
      attr_q <= attr_d;
    end
  end

  assign cfg_err     = err_q;
  assign hit         = hit_q;
  assign hit_region  = idx_q;
  assign hit_encrypt = enc_q;
  assign hit_attr    = attr_q;

endmodule

// File: rtl/enc_rm_checker.sv
module enc_rm_checker #(
  parameter int unsigned LW    = 24,
  parameter int unsigned DW    = 16,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned AW    = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic [2:0]      cfg_sel,
  input logic [AW-1:0]   cfg_wdata,
  input logic            cfg_err,
  input logic            glob_q,
  input logic            hit,
  input logic [IDX_W-1:0] hit_region,
  input logic            hit_encrypt,
  input logic [3:0]      hit_attr,
  input logic [LW-1:0]   lock_flat,
  input logic [DW-1:0]   dlock_flat
);

  logic bad_bound;
  assign bad_bound = cfg_we && (cfg_sel == 3'd0 || cfg_sel == 3'd1) && (cfg_wdata[2:0] != 3'd0);

  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_flat & $past(lock_flat)) == $past(lock_flat)));

  assert_dom_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dlock_flat & $past(dlock_flat)) == $past(dlock_flat)));

  assert_global_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_q |=> !hit);

  assert_idle_outputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_region == '0 && !hit_encrypt && hit_attr == 4'h0));

  assert_err_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_bound |=> cfg_err);

  assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_bound |=> !cfg_err);

endmodule

bind enc_region_matcher enc_rm_checker #(
  .LW    (NUM_REGIONS * 3),
  .DW    (NUM_REGIONS * NUM_DOMAINS),
  .IDX_W (IDX_W),
  .AW    (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_sel     (cfg_sel),
  .cfg_wdata   (cfg_wdata),
  .cfg_err     (cfg_err),
  .glob_q      (glob_q),
  .hit         (hit),
  .hit_region  (hit_region),
  .hit_encrypt (hit_encrypt),
  .hit_attr    (hit_attr),
  .lock_flat   (lock_flat),
  .dlock_flat  (dlock_flat)
);

// File: tb/enc_region_matcher_test.sv
module enc_region_matcher_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  // {addr[40:9], hit[8], region[7:5], encrypt[4], attr[3:0]}
  localparam logic [40:0] VEC [NV] = '{
    {32'h0000_0FF8, 1'b0, 3'd0, 1'b0, 4'h0},
    {32'h0000_1000, 1'b1, 3'd0, 1'b1, 4'h0},
    {32'h0000_1FFF, 1'b1, 3'd0, 1'b1, 4'h0},
    {32'h0000_2000, 1'b1, 3'd1, 1'b0, 4'h1},
    {32'h0000_1800, 1'b1, 3'd0, 1'b1, 4'h0},
    {32'h0000_2FF8, 1'b1, 3'd1, 1'b0, 4'h1},
    {32'h0000_3000, 1'b0, 3'd0, 1'b0, 4'h0},
    {32'h0000_4000, 1'b1, 3'd2, 1'b1, 4'hA},
    {32'h0000_6800, 1'b0, 3'd0, 1'b0, 4'h0},
    {32'h9000_0000, 1'b1, 3'd7, 1'b0, 4'h4},
    {32'hFFFF_FFF8, 1'b0, 3'd0, 1'b0, 4'h0},
    {32'hFFFF_FFF0, 1'b1, 3'd7, 1'b0, 4'h4}
  };

  logic        clk, rst_n, cfg_we, cfg_err, hit, hit_encrypt;
  logic [2:0]  cfg_sel, cfg_region, hit_region;
  logic [0:0]  cfg_domain;
  logic [31:0] cfg_wdata, lookup_addr;
  logic [3:0]  hit_attr;
  int checks, failures;

  enc_region_matcher uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_region(cfg_region), .cfg_domain(cfg_domain), .cfg_wdata(cfg_wdata),
    .cfg_err(cfg_err), .lookup_addr(lookup_addr), .hit(hit),
    .hit_region(hit_region), .hit_encrypt(hit_encrypt), .hit_attr(hit_attr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic dom, input logic [2:0] reg_i, input logic [2:0] sel,
                    input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_domain = dom; cfg_region = reg_i; cfg_sel = sel; cfg_wdata = data;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic look(input logic [31:0] a);
    @(negedge clk);
    lookup_addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_hit(input string req, input logic [31:0] a, input logic h,
                            input logic [2:0] r);
    look(a);
    chk(req, {63'd0, hit}, {63'd0, h});
    if (h) chk(req, {61'd0, hit_region}, {61'd0, r});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    cfg_we = 0; cfg_sel = 0; cfg_region = 0; cfg_domain = 0; cfg_wdata = 0;
    lookup_addr = 0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    chk("R10 hit", {63'd0, hit}, 64'd0);
    chk("R10 err", {63'd0, cfg_err}, 64'd0);
    wr(0, 0, 3'd4, 32'h1);
    expect_hit("R10 empty table", 32'h0, 1'b0, 3'd0);

    // table configuration
    wr(0, 0, 3'd0, 32'h0000_1000); wr(0, 0, 3'd1, 32'h0000_2000); wr(0, 0, 3'd2, 32'h21);
    wr(0, 1, 3'd0, 32'h0000_1800); wr(0, 1, 3'd1, 32'h0000_3000); wr(0, 1, 3'd2, 32'h03);
    wr(0, 2, 3'd0, 32'h0000_4000); wr(0, 2, 3'd1, 32'h0000_5000); wr(0, 2, 3'd2, 32'h35);
    wr(0, 3, 3'd0, 32'h0000_6000); wr(0, 3, 3'd1, 32'h0000_7000); wr(0, 3, 3'd2, 32'h00);
    wr(1, 7, 3'd0, 32'h8000_0000); wr(1, 7, 3'd1, 32'hFFFF_FFF8); wr(1, 7, 3'd2, 32'h09);

    // R1 R2 R3 R5: vector table
    for (int i = 0; i < NV; i++) begin
      look(VEC[i][40:9]);
      chk("R2 hit", {63'd0, hit}, {63'd0, VEC[i][8]});
      chk("R3 region", {61'd0, hit_region}, {61'd0, VEC[i][7:5]});
      chk("R5 encrypt", {63'd0, hit_encrypt}, {63'd0, VEC[i][4]});
      chk("R5 attr", {60'd0, hit_attr}, {60'd0, VEC[i][3:0]});
    end

    // R1: output follows the address of the previous edge only
    @(negedge clk); lookup_addr = 32'h0000_1000;
    @(posedge clk); @(negedge clk); lookup_addr = 32'h0000_0000;
    chk("R1 registered hit", {63'd0, hit}, 64'd1);
    @(posedge clk); @(negedge clk);
    chk("R1 next miss", {63'd0, hit}, 64'd0);

    // R4: global enable
    wr(0, 0, 3'd4, 32'h0);
    expect_hit("R4 global off", 32'h0000_1000, 1'b0, 3'd0);
    wr(0, 0, 3'd4, 32'h1);
    expect_hit("R4 global on", 32'h0000_1000, 1'b1, 3'd0);

    // R6: misaligned bound
    wr(0, 0, 3'd0, 32'h0000_0804);
    chk("R6 err raised", {63'd0, cfg_err}, 64'd1);
    expect_hit("R6 bound unchanged", 32'h0000_0808, 1'b0, 3'd0);
    wr(0, 0, 3'd1, 32'h0000_2000);
    chk("R6 err quiet", {63'd0, cfg_err}, 64'd0);

    // R7: freeze bits
    wr(0, 2, 3'd5, 32'h1);
    wr(0, 2, 3'd0, 32'h0000_3000);
    expect_hit("R7 bottom frozen", 32'h0000_3800, 1'b0, 3'd0);
    wr(0, 2, 3'd5, 32'h4);
    wr(0, 2, 3'd2, 32'h00);
    expect_hit("R7 attr frozen", 32'h0000_4000, 1'b1, 3'd2);
    chk("R7 attr frozen encrypt", {63'd0, hit_encrypt}, 64'd1);
    wr(0, 2, 3'd5, 32'h0);
    wr(1, 2, 3'd2, 32'h00);
    expect_hit("R7 freeze set-only", 32'h0000_4000, 1'b1, 3'd2);
    wr(0, 2, 3'd1, 32'h0000_4800);
    expect_hit("R7 top still open", 32'h0000_4800, 1'b0, 3'd0);
    expect_hit("R7 top below", 32'h0000_47F8, 1'b1, 3'd2);

    // R9: domain write-disable
    wr(0, 1, 3'd3, 32'h1);
    wr(0, 1, 3'd0, 32'h0000_2800);
    expect_hit("R9 domain0 blocked", 32'h0000_2000, 1'b1, 3'd1);
    wr(1, 1, 3'd0, 32'h0000_2800);
    expect_hit("R9 domain1 accepted", 32'h0000_2000, 1'b0, 3'd0);
    expect_hit("R9 domain1 new bottom", 32'h0000_2800, 1'b1, 3'd1);

    // R8: domain control freeze
    wr(0, 1, 3'd3, 32'h0);
    wr(0, 1, 3'd1, 32'h0000_3800);
    expect_hit("R8 unlocked ctl cleared", 32'h0000_3000, 1'b1, 3'd1);
    wr(1, 1, 3'd3, 32'h3);
    wr(1, 1, 3'd1, 32'h0000_3000);
    expect_hit("R8 domain1 disabled", 32'h0000_3000, 1'b1, 3'd1);
    wr(1, 1, 3'd3, 32'h0);
    wr(1, 1, 3'd1, 32'h0000_3000);
    expect_hit("R8 ctl frozen", 32'h0000_3000, 1'b1, 3'd1);
    wr(0, 1, 3'd1, 32'h0000_3000);
    expect_hit("R9 other domain open", 32'h0000_3000, 1'b0, 3'd0);

    // R10 / R7: reset clears everything, freezes included
    do_reset();
    expect_hit("R10 after reset", 32'h0000_1000, 1'b0, 3'd0);
    wr(0, 0, 3'd4, 32'h1);
    wr(0, 2, 3'd0, 32'h0000_3000); wr(0, 2, 3'd1, 32'h0000_4000); wr(0, 2, 3'd2, 32'h01);
    expect_hit("R7 reset unfreezes", 32'h0000_3800, 1'b1, 3'd2);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule